// File: doc/BRIEF.md
# Split-Operand Unsigned Multiplier

This block multiplies two unsigned operands of width 2N and returns the full 4N-bit product in the same cycle. There are no registers in the block. Each operand is split into a high half and a low half of N bits. Four N×N unsigned submultipliers form the low-by-low, low-by-high, high-by-low and high-by-high products. The block aligns these four products by weight and sums them into the final result.

The alignment keeps the summation matrix at its minimum height:

- The low-by-low product and the high-by-high product never overlap, so they are packed side by side into a single 4N-bit row.
- The two cross products sit at weight N.
- The bottom N bits of the packed row are already final and are passed straight to the output.
- The 2N centre columns hold exactly three operands. One carry-save level reduces them to two.
- A single 3N-bit carry-propagate adder merges the carry-save result with the top N bits of the packed row. Its carry out is dropped, because the exact product always fits in 4N bits.

Top module: `split_mult`

## Requirements
- R1: `prod_out` equals the exact unsigned product of `a_in` and `x_in` for every pair of operands.
- R2: Bits N-1..0 of `prod_out` equal the low N bits of the product of the low halves `a_in[N-1:0]` and `x_in[N-1:0]`, with no addition applied to them.
- R3: When either operand is zero, `prod_out` is zero.
- R4: When both operands are all ones, `prod_out` equals (2^(2N)-1)^2. For N=8 this is 32'hFFFE0001.
- R5: The carry out of the 3N-bit carry-propagate adder is zero for every pair of operands.
- R6: Each N×N submultiplier returns the exact 2N-bit product of its two halves.
- R7: When one operand is 1, `prod_out` equals the other operand, zero-extended to 4N bits.
- R8: The output depends only on the present inputs. A new operand pair shows its product within the same clock period, with no clock or reset involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 2N | Unsigned multiplicand |
| x_in | input | 2N | Unsigned multiplier |
| prod_out | output | 4N | Unsigned 4N-bit product |

## Verification
Random operand pairs with a fixed seed exercise every alignment path at once. Operands with only one non-zero half isolate each submultiplier and its placement weight. Zero and one operands show whether a cross product is misplaced or left over. All-ones operands push the most carries through the carry-save level into the top N columns, which exposes a dropped or misrouted carry. Operands whose low halves alone are non-zero confirm that the bottom N bits pass through untouched.

// File: rtl/split_mult_pkg.sv
// Package: shared full-adder helpers for the split multiplier.
// Assumes: single-bit operands; purely combinational use.
package split_mult_pkg;
    function automatic logic fa_s(input logic a, input logic b, input logic c);
        return a ^ b ^ c;
    endfunction

    function automatic logic fa_c(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction
endpackage

// File: rtl/array_mul.sv
// Module: array_mul - unsigned NxN array multiplier built from shifted-row accumulation.
// Assumes: unsigned operands; the output is exactly 2N bits wide, so nothing is lost.
module array_mul #(
    parameter int N = 8
) (
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    output logic [2*N-1:0] prod
);
    localparam int PW = 2 * N;

    logic [PW-1:0] acc [N+1];

    assign acc[0] = '0;

    // one row per multiplier bit: add the shifted multiplicand when the bit is set
    for (genvar r = 0; r < N; r++) begin : g_row
        logic [PW-1:0] row_pp;
        assign row_pp = op_b[r] ? (PW'(op_a) << r) : '0;
        assign acc[r+1] = acc[r] + row_pp;
    end

    assign prod = acc[N];

    // check the array sum against the exact product of the two halves
    always_comb begin
        // R6
        sub_exact_chk: assert (prod == (PW'(op_a) * PW'(op_b)));
    end
endmodule

// File: rtl/csa_row.sv
// Module: csa_row - W-bit carry-save adder reducing three operands to a sum and a carry vector.
// Assumes: the carry vector carries weight one position above its index.
module csa_row
    import split_mult_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    output logic [W-1:0] sum_v,
    output logic [W-1:0] cry_v
);
    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum_v[i] = fa_s(in_a[i], in_b[i], in_c[i]);
        assign cry_v[i] = fa_c(in_a[i], in_b[i], in_c[i]);
    end

    // the reduced pair must carry the same total as the three inputs
    always_comb begin
        // R1
        csa_sum_chk: assert (({1'b0, sum_v} + {cry_v, 1'b0}) ==
                             ((W+1)'(in_a) + (W+1)'(in_b) + (W+1)'(in_c)));
    end
endmodule

// File: rtl/ripple_cpa.sv
// Module: ripple_cpa - W-bit ripple carry-propagate adder with a carry out.
// Assumes: carry in is zero.
module ripple_cpa
    import split_mult_pkg::*;
#(
    parameter int W = 24
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] cch;

    assign cch[0] = 1'b0;

    // ripple the carry one bit at a time
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]   = fa_s(in_a[i], in_b[i], cch[i]);
        assign cch[i+1] = fa_c(in_a[i], in_b[i], cch[i]);
    end

    assign cout = cch[W];
endmodule

// File: rtl/split_mult.sv
// Module: split_mult - unsigned 2Nx2N multiplier made from four NxN submultipliers.
// Assumes: unsigned operands; combinational; the product fits in 4N bits, so the CPA carry out is dropped.
module split_mult #(
    parameter int N = 8
) (
    input  logic [2*N-1:0] a_in,
    input  logic [2*N-1:0] x_in,
    output logic [4*N-1:0] prod_out
);
    localparam int HW = 2 * N;
    localparam int CW = 3 * N;
    localparam int PW = 4 * N;

    logic [HW-1:0] pp_ll, pp_lh, pp_hl, pp_hh;
    logic [PW-1:0] packed_row;
    logic [HW-1:0] mid_a, mid_s, mid_c;
    logic [CW-1:0] cpa_a, cpa_b, cpa_s;
    logic          cpa_co;

    // four submultipliers, one per pairing of operand halves
    array_mul #(.N(N)) u_ll (.op_a(a_in[N-1:0]),  .op_b(x_in[N-1:0]),  .prod(pp_ll));
    array_mul #(.N(N)) u_lh (.op_a(a_in[N-1:0]),  .op_b(x_in[HW-1:N]), .prod(pp_lh));
    array_mul #(.N(N)) u_hl (.op_a(a_in[HW-1:N]), .op_b(x_in[N-1:0]),  .prod(pp_hl));
    array_mul #(.N(N)) u_hh (.op_a(a_in[HW-1:N]), .op_b(x_in[HW-1:N]), .prod(pp_hh));

    // low-low and high-high products never overlap: pack them into one row
    assign packed_row = {pp_hh, pp_ll};
    assign mid_a      = packed_row[CW-1:N];

    // the centre columns hold three operands: one carry-save level
    csa_row #(.W(HW)) u_csa (
        .in_a(mid_a), .in_b(pp_lh), .in_c(pp_hl),
        .sum_v(mid_s), .cry_v(mid_c)
    );

    // the CPA covers the centre columns and the top N columns
    assign cpa_a = {packed_row[PW-1:CW], mid_s};
    assign cpa_b = {{(N-1){1'b0}}, mid_c, 1'b0};

    ripple_cpa #(.W(CW)) u_cpa (.in_a(cpa_a), .in_b(cpa_b), .sum(cpa_s), .cout(cpa_co));

    // the bottom N bits of the packed row are already final
    assign prod_out = {cpa_s, packed_row[N-1:0]};

    // guard the dropped carry and the untouched low slice
    always_comb begin
        // R5
        cpa_no_carry_chk: assert (!cpa_co);
        // R2
        low_pass_chk: assert (prod_out[N-1:0] == pp_ll[N-1:0]);
    end
endmodule

// File: tb/sim_split_mult.sv
// Bench: sim_split_mult - random and directed checks of split_mult against a native multiply.
module sim_split_mult;
    localparam int N  = 8;
    localparam int HW = 2 * N;
    localparam int PW = 4 * N;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [HW-1:0] a_in = '0, x_in = '0;
    logic [PW-1:0] prod_out;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    split_mult #(.N(N)) u0 (.a_in(a_in), .x_in(x_in), .prod_out(prod_out));

    function automatic logic [PW-1:0] ref_prod(input logic [HW-1:0] a, input logic [HW-1:0] b);
        return PW'(a) * PW'(b);
    endfunction

    task automatic check(input string req, input logic [PW-1:0] got, input logic [PW-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s a=%h x=%h got=%h exp=%h", req, a_in, x_in, got, exp);
        end
    endtask

    // drive on the falling edge, sample one time unit after the next rising edge
    task automatic apply(input logic [HW-1:0] a, input logic [HW-1:0] b);
        @(negedge clk);
        a_in = a;
        x_in = b;
        @(posedge clk);
        #1;
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // R3: reset-state inputs of zero give a zero product
        #1 check("R3", prod_out, '0);
        // R4: all ones
        apply('1, '1);
        check("R4", prod_out, 32'hFFFE0001);
        // R3: one operand zero
        apply('1, '0);
        check("R3", prod_out, '0);
        apply('0, 16'h1234);
        check("R3", prod_out, '0);
        // R7: one operand is one
        apply(16'h1, 16'hBEEF);
        check("R7", prod_out, PW'(16'hBEEF));
        apply(16'hCAFE, 16'h1);
        check("R7", prod_out, PW'(16'hCAFE));
        // R6: isolate each submultiplier through single-half operands
        apply(16'h00FF, 16'h00FF);
        check("R6", prod_out, ref_prod(16'h00FF, 16'h00FF));
        apply(16'h00FF, 16'hFF00);
        check("R6", prod_out, ref_prod(16'h00FF, 16'hFF00));
        apply(16'hFF00, 16'h00FF);
        check("R6", prod_out, ref_prod(16'hFF00, 16'h00FF));
        apply(16'hFF00, 16'hFF00);
        check("R6", prod_out, ref_prod(16'hFF00, 16'hFF00));
        // R2: low slice comes from the low halves only
        apply(16'hA5C3, 16'h5A7D);
        check("R2", PW'(prod_out[N-1:0]), PW'(8'(8'hC3 * 8'h7D)));
        // R1, R8: random operands, product visible within the same period
        for (int i = 0; i < 400; i++) begin
            logic [HW-1:0] ra, rb;
            ra = HW'($urandom);
            rb = HW'($urandom);
            apply(ra, rb);
            check("R1", prod_out, ref_prod(ra, rb));
        end
        // R8: a new pair shows its product one time unit after the drive, no edge needed
        @(negedge clk);
        a_in = 16'h7FFF;
        x_in = 16'h8001;
        #1 check("R8", prod_out, ref_prod(16'h7FFF, 16'h8001));
        done = 1'b1;
    end

    // watchdog: a hung run counts as a failure and still reaches the summary
    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog expired got=running exp=done");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule